// File: doc/BRIEF.md
# Proportional-Integral Digital Loop Filter

This block is the loop filter of an all-digital phase-locked loop. Once per cycle of the fast digital clock it takes a phase measurement in two parts. The first is a 7-bit thermometer code from a fine phase detector. The second is a pair of coarse up/down flags from a bang-bang frequency detector. It merges the two into one signed error. It then forms a frequency control word as the sum of two terms. One is a proportional term, the error scaled by alpha. The other is an integral term, a running sum of the error scaled by beta. The word goes to a downstream noise-shaping modulator.

Both gains are powers of two, so each one is an arithmetic right shift. The shift amounts come from two 4-bit configuration fields. Suitable settings are 5 for alpha and 11 for beta. The fields are captured only while the filter is in reset or while the loop is disabled, so a setting cannot change while the loop is running. The integral sum saturates instead of wrapping. The output is a two's-complement word with 10 integer bits and 15 fractional bits. The filter is meant to be clocked well above the reference rate, for example ten times faster, to shorten the effective loop delay.

Top module: `pi_loop_filter`

## Requirements
- R1: A synchronous active-high `rst` clears the integral accumulator and `fcw_out` to zero on the next clock edge, and loads the alpha and beta shift amounts from `cfg_alpha_shift` and `cfg_beta_shift`.
- R2: The fine error is 2·n − 7, where n is the number of ones in `phase_thermo`, counted without regard to bit position. A non-monotonic (bubbled) code therefore gives the same error as a clean code with the same count. The range is −7 to +7 in odd steps.
- R3: When n lies between 1 and 6, `freq_up` and `freq_dn` are ignored and the error equals the fine error.
- R4: When n is 0 or 7, `freq_up` alone substitutes an error of +8, and `freq_dn` alone substitutes −8. With both flags set or neither set, the fine error is used.
- R5: In each enabled cycle the accumulator adds (error·2^15) arithmetically shifted right by the beta shift, rounding toward minus infinity.
- R6: `fcw_out` is a 10.15 two's-complement word. It equals the updated accumulator plus (error·2^15) shifted right arithmetically by the alpha shift. Inputs sampled at clock edge k appear on `fcw_out` after edge k+1.
- R7: The accumulator and `fcw_out` saturate at +2^24−1 and −2^24 (raw 25-bit values) and never wrap.
- R8: The shift amounts are captured only while `rst` is high or `loop_en` is low. Changes to the configuration fields while the loop is enabled have no effect on `fcw_out`.
- R9: While `loop_en` is low, the accumulator and `fcw_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digital loop clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_en | input | 1 | Loop running; when low, the filter state holds and the gains are captured |
| cfg_alpha_shift | input | 4 | Proportional gain as a right-shift amount |
| cfg_beta_shift | input | 4 | Integral gain as a right-shift amount |
| phase_thermo | input | 7 | Fine phase detector thermometer code |
| freq_up | input | 1 | Coarse detector: output frequency too low |
| freq_dn | input | 1 | Coarse detector: output frequency too high |
| fcw_out | output | 25 | Frequency control word, signed 10.15 |

## Verification
The hardest states to reach are the two saturation limits of the accumulator. With the suggested gains, a coarse error of ±8 adds only a few LSBs per cycle, so full scale would take far longer than any run. The stimulus therefore sets both shifts to zero while the loop is disabled, then holds the thermometer code full with the up flag set. This drives the sum to the positive rail in about 64 cycles and keeps pressing against it. The same is then done in the negative direction. The bench also disables the loop, changes the gains, re-enables, and changes the gains again while running. This shows that only the value captured while disabled takes effect.

// File: rtl/pilf_pkg.sv
package pilf_pkg;
  // Origin of the error word chosen by the dead-zone merge
  typedef enum logic [1:0] {
    SRC_FINE   = 2'd0,
    SRC_UP     = 2'd1,
    SRC_DN     = 2'd2
  } err_src_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pilf_err_decode.sv
module pilf_err_decode
  import pilf_pkg::*;
#(
  parameter int THERMO_W   = 7,
  parameter int COARSE_MAG = 8,
  parameter int ERR_W      = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [THERMO_W-1:0]     thermo,
  input  logic                    up,
  input  logic                    dn,
  output logic signed [ERR_W-1:0] err_q
);
  localparam int CNT_W = $clog2(THERMO_W + 1);
  localparam logic signed [ERR_W-1:0] MID    = ERR_W'(THERMO_W);
  localparam logic signed [ERR_W-1:0] COARSE = ERR_W'(COARSE_MAG);

  logic [CNT_W-1:0]        ones;
  logic signed [ERR_W-1:0] fine;
  logic                    at_edge;
  err_src_e                src;
  logic signed [ERR_W-1:0] err_d;

  // plain population count tolerates bubbles
  always_comb begin
    ones = '0;
    for (int i = 0; i < THERMO_W; i++) ones = ones + CNT_W'(thermo[i]);
  end

  assign fine    = ERR_W'({ones, 1'b0}) - MID;
  assign at_edge = (ones == '0) || (ones == CNT_W'(THERMO_W));

  always_comb begin
    src = SRC_FINE;
    if (at_edge && up && !dn) src = SRC_UP;
    else if (at_edge && dn && !up) src = SRC_DN;
  end

  always_comb begin
    unique case (src)
      SRC_UP:  err_d = COARSE;
      SRC_DN:  err_d = -COARSE;
      default: err_d = fine;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_d;
  end
endmodule

// File: rtl/pilf_shift_scale.sv
module pilf_shift_scale #(
  parameter int ERR_W   = 5,
  parameter int FRAC_W  = 15,
  parameter int SHIFT_W = 4,
  parameter int OUT_W   = 25
) (
  input  logic signed [ERR_W-1:0] err,
  input  logic [SHIFT_W-1:0]      shift,
  output logic signed [OUT_W-1:0] scaled
);
  logic signed [OUT_W-1:0] aligned;

  generate
    if (ERR_W + FRAC_W <= OUT_W) begin : g_fit
      always_comb aligned = OUT_W'(err) <<< FRAC_W;
    end else begin : g_clip
      logic signed [ERR_W+FRAC_W-1:0] wide;
      always_comb begin
        wide    = (ERR_W+FRAC_W)'(err) <<< FRAC_W;
        aligned = OUT_W'(wide);
      end
    end
  endgenerate

  assign scaled = aligned >>> shift;
endmodule

// File: rtl/pilf_sat_add.sv
module pilf_sat_add #(
  parameter int W = 25
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  logic signed [W:0] sum;

  assign sum = {a[W-1], a} + {b[W-1], b};

  always_comb begin
    if (sum[W] != sum[W-1]) y = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else                    y = sum[W-1:0];
  end
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
  import pilf_pkg::*;
#(
  parameter int THERMO_W   = 7,
  parameter int COARSE_MAG = 8,
  parameter int INT_W      = 10,
  parameter int FRAC_W     = 15,
  parameter int SHIFT_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      loop_en,
  input  logic [SHIFT_W-1:0]        cfg_alpha_shift,
  input  logic [SHIFT_W-1:0]        cfg_beta_shift,
  input  logic [THERMO_W-1:0]       phase_thermo,
  input  logic                      freq_up,
  input  logic                      freq_dn,
  output logic [INT_W+FRAC_W-1:0]   fcw_out
);
  localparam int OUT_W = INT_W + FRAC_W;
  localparam int ERR_W = $clog2(max_int(COARSE_MAG, THERMO_W) + 1) + 1;

  logic signed [ERR_W-1:0] err_q;
  logic [SHIFT_W-1:0]      alpha_q, beta_q;
  logic signed [OUT_W-1:0] prop_inc, int_inc;
  logic signed [OUT_W-1:0] acc_q, acc_next, fcw_q, fcw_next;

  pilf_err_decode #(
    .THERMO_W(THERMO_W), .COARSE_MAG(COARSE_MAG), .ERR_W(ERR_W)
  ) u_dec (
    .clk(clk), .rst(rst), .thermo(phase_thermo),
    .up(freq_up), .dn(freq_dn), .err_q(err_q)
  );

  pilf_shift_scale #(
    .ERR_W(ERR_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)
  ) u_prop (.err(err_q), .shift(alpha_q), .scaled(prop_inc));

  pilf_shift_scale #(
    .ERR_W(ERR_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)
  ) u_int (.err(err_q), .shift(beta_q), .scaled(int_inc));

  pilf_sat_add #(.W(OUT_W)) u_acc_add (.a(acc_q),    .b(int_inc),  .y(acc_next));
  pilf_sat_add #(.W(OUT_W)) u_out_add (.a(acc_next), .b(prop_inc), .y(fcw_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      alpha_q <= cfg_alpha_shift;
      beta_q  <= cfg_beta_shift;
      acc_q   <= '0;
      fcw_q   <= '0;
    end else if (!loop_en) begin
      alpha_q <= cfg_alpha_shift;
      beta_q  <= cfg_beta_shift;
    end else begin
      acc_q <= acc_next;
      fcw_q <= fcw_next;
    end
  end

  assign fcw_out = fcw_q;
endmodule

// File: rtl/pilf_checker.sv
module pilf_checker #(
  parameter int THERMO_W = 7,
  parameter int ERR_W    = 5,
  parameter int SHIFT_W  = 4,
  parameter int OUT_W    = 25
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    loop_en,
  input logic [THERMO_W-1:0]     phase_thermo,
  input logic [OUT_W-1:0]        fcw_out,
  input logic signed [OUT_W-1:0] acc_q,
  input logic signed [ERR_W-1:0] err_q,
  input logic [SHIFT_W-1:0]      alpha_q,
  input logic [SHIFT_W-1:0]      beta_q
);
  localparam logic signed [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [ERR_W-1:0] FMAX = ERR_W'(THERMO_W);

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (fcw_out == '0 && acc_q == '0));

  // R9
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> ($stable(fcw_out) && $stable(acc_q)));

  // R8
  gain_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> ($stable(alpha_q) && $stable(beta_q)));

  // R3
  fine_range_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(phase_thermo) > 0 && $countones(phase_thermo) < THERMO_W)
      |=> (err_q <= FMAX && err_q >= -FMAX));

  // R7
  sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_q == MAXV && loop_en && !err_q[ERR_W-1]) |=> acc_q == MAXV);

  // R7
  sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_q == MINV && loop_en && err_q[ERR_W-1]) |=> acc_q == MINV);
endmodule

bind pi_loop_filter pilf_checker #(
  .THERMO_W(THERMO_W), .ERR_W(ERR_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .loop_en(loop_en), .phase_thermo(phase_thermo),
  .fcw_out(fcw_out), .acc_q(acc_q), .err_q(err_q),
  .alpha_q(alpha_q), .beta_q(beta_q)
);

// File: tb/pi_loop_filter_bench.sv
module pi_loop_filter_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        loop_en;
  logic [3:0]  cfg_a, cfg_b;
  logic [6:0]  thermo;
  logic        up, dn;
  logic [24:0] fcw_out;

  int vectors = 0;
  int fails   = 0;
  string req  = "R1";

  longint m_err, m_acc, m_fcw;
  int     m_a, m_b;

  localparam longint MAXV = (64'sd1 <<< 24) - 1;
  localparam longint MINV = -(64'sd1 <<< 24);

  always #10 clk = ~clk;

  pi_loop_filter u_pi_loop_filter (
    .clk(clk), .rst(rst), .loop_en(loop_en),
    .cfg_alpha_shift(cfg_a), .cfg_beta_shift(cfg_b),
    .phase_thermo(thermo), .freq_up(up), .freq_dn(dn), .fcw_out(fcw_out)
  );

  function automatic longint sat(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  // R2 R3 R4: error word from the requirement text
  function automatic longint err_of(input logic [6:0] t, input logic u, input logic d);
    int n = $countones(t);
    if ((n == 0 || n == 7) && u && !d) return 8;
    if ((n == 0 || n == 7) && d && !u) return -8;
    return 2 * n - 7;
  endfunction

  task automatic cycle();
    @(posedge clk);
    if (rst) begin
      m_acc = 0; m_fcw = 0; m_a = cfg_a; m_b = cfg_b; m_err = 0;
    end else begin
      if (loop_en) begin
        m_acc = sat(m_acc + ((m_err * 32768) >>> m_b));
        m_fcw = sat(m_acc + ((m_err * 32768) >>> m_a));
      end else begin
        m_a = cfg_a; m_b = cfg_b;
      end
      m_err = err_of(thermo, up, dn);
    end
    @(negedge clk);
    vectors++;
    if ($signed(fcw_out) != m_fcw) begin
      fails++;
      $display("FAIL %s: fcw_out=%0d expected=%0d at vector %0d",
               req, $signed(fcw_out), m_fcw, vectors);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    m_err = 0; m_acc = 0; m_fcw = 0; m_a = 0; m_b = 0;
    rst = 1; loop_en = 0; cfg_a = 4'd5; cfg_b = 4'd11;
    thermo = 7'b0000111; up = 0; dn = 0;
    @(negedge clk);
    // R1: reset state
    req = "R1"; run(3);
    rst = 0; loop_en = 1;

    // R2: clean and bubbled codes, counted as ones
    req = "R2";
    thermo = 7'b0001111; run(4);
    thermo = 7'b0101101; run(4);
    thermo = 7'b0000001; run(3);
    thermo = 7'b1011111; run(3);
    for (int k = 0; k < 40; k++) begin
      thermo = 7'((k * 37 + 11) % 128); run(1);
    end

    // R3: flags inside the fine range are ignored
    req = "R3";
    for (int k = 0; k < 30; k++) begin
      thermo = (k % 2) ? 7'b0011111 : 7'b0000011;
      up = k[0]; dn = k[1]; run(1);
    end

    // R4: coarse substitution at the range ends
    req = "R4";
    thermo = 7'b1111111; up = 1; dn = 0; run(5);
    thermo = 7'b0000000; up = 0; dn = 1; run(5);
    thermo = 7'b1111111; up = 1; dn = 1; run(3);
    thermo = 7'b0000000; up = 0; dn = 0; run(3);
    thermo = 7'b0000000; up = 1; dn = 0; run(3);
    up = 0;

    // R5 R6: integral and proportional paths at several gains
    req = "R5 R6";
    loop_en = 0; cfg_a = 4'd2; cfg_b = 4'd7; run(2);
    loop_en = 1;
    for (int k = 0; k < 30; k++) begin
      thermo = (k % 3 == 0) ? 7'b0000001 : 7'b0111111; run(1);
    end
    loop_en = 0; cfg_a = 4'd15; cfg_b = 4'd15; run(2);
    loop_en = 1; thermo = 7'b0000000; dn = 1; run(10); dn = 0;

    // R8: config changes while running are ignored
    req = "R8";
    cfg_a = 4'd0; cfg_b = 4'd0; thermo = 7'b0111111; run(12);
    cfg_a = 4'd9; cfg_b = 4'd3; run(6);

    // R9: hold while disabled, then new gains take effect
    req = "R9";
    loop_en = 0; thermo = 7'b1111111; up = 1; run(8);
    up = 0; thermo = 7'b0001111;
    loop_en = 1; run(6);

    // R7: drive to both rails with zero shifts
    req = "R7";
    loop_en = 0; cfg_a = 4'd0; cfg_b = 4'd0; run(2);
    loop_en = 1; thermo = 7'b1111111; up = 1; run(80);
    up = 0; thermo = 7'b0000000; dn = 1; run(150);
    dn = 0; thermo = 7'b1111111; up = 1; run(10); up = 0;

    // R1: reset mid-run clears state
    req = "R1";
    rst = 1; cfg_a = 4'd5; cfg_b = 4'd11; run(2);
    rst = 0; thermo = 7'b0111111; run(6);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule